// File: doc/BRIEF.md
# Per-bunch luminosity scaler bank

This block keeps online luminosity counts for every bunch slot of the accelerator orbit. Each clock cycle is one bunch crossing. On each crossing the block receives a 16-tube hit summary from detector side A and one from side C, an orbit marker, and a level-1 accept strobe. It numbers the slots itself, starting from the marker. While a counting interval is open, it adds that crossing's contribution to four counters stored at that slot's address.

The counters live in one read-modify-write memory. Each word holds the four per-slot counters. The four counters are:
- events with any hit,
- events with hits on both sides,
- the total number of hit tubes,
- the total number of hit tubes on coincidence crossings only.

A separate counter records how many orbits the interval spans, which is needed for averaging. A host opens and closes the interval, and both requests take effect only on an orbit marker. The host reads a counter with a one-cycle-latency read port once per luminosity block. A sweep that zeroes the whole bank runs after reset and on host request.

Top module: `lumi_bunch_scaler`

## Requirements
- R1: The crossing that carries `orbit_mark` is slot 0. Each following crossing is the next slot, and the count wraps from NUM_SLOTS-1 (3563 by default) to 0 if no marker arrives.
- R2: `orbit_err` becomes 1 when a marker arrives while the previous crossing was not slot NUM_SLOTS-1. The first marker after reset never sets it. It stays set until an accepted host clear.
- R3: `host_start` and `host_stop` only arm a pending request, and `interval_active` changes only at a marker crossing. The marker crossing itself is counted under the new state. If both requests arrive in the same cycle, stop wins.
- R4: A crossing changes the slot counters only if `l1a` is 1 and the interval is open for that crossing.
- R5: Read selects 0 to 3 return the slot's counters:
  - 0: events with any tube hit on either side (+1),
  - 1: events with hits on both sides (+1),
  - 2: hit tubes on both sides summed,
  - 3: the same tube sum, but only on two-sided crossings.
- R6: Read select 4 returns the orbit counter. It increments at each marker for which the interval is open.
- R7: Every counter, including the orbit counter, saturates at all ones (CNT_W bits, 32 by default) instead of wrapping.
- R8: Updates to the same slot in back-to-back cycles accumulate with no lost increment.
- R9: When `rd_en` is 1 in a cycle, `rd_valid` is 1 in the next cycle, with `rd_data` taken from the state before that edge. A slot address of NUM_SLOTS or above, or a select of 5 to 7, returns 0.
- R10: Reset, and an accepted `host_clear`, start a sweep with `clr_busy` high for NUM_SLOTS cycles. The sweep zeroes all four arrays, the orbit counter and `orbit_err`. A clear is ignored while the interval is open, while a start is pending, or while a sweep runs.
- R11: `host_start` is ignored while `clr_busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crossing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| orbit_mark | input | 1 | Marks the first crossing of an orbit |
| l1a | input | 1 | Level-1 accept for this crossing |
| hits_a | input | TUBES | Hit tubes, side A |
| hits_c | input | TUBES | Hit tubes, side C |
| host_start | input | 1 | Request to open the interval at the next marker |
| host_stop | input | 1 | Request to close the interval at the next marker |
| host_clear | input | 1 | Request to zero the bank |
| rd_en | input | 1 | Host read strobe |
| rd_sel | input | 3 | Read select: 0 to 3 arrays, 4 orbit counter |
| rd_addr | input | SLOT_W | Slot address for reads |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | CNT_W | Read data |
| interval_active | output | 1 | Counting interval open |
| clr_busy | output | 1 | Clear sweep running |
| orbit_err | output | 1 | Sticky orbit-length error |

## Verification
The embedded properties watch several behaviours on every cycle:
- slot numbering steps by one between markers,
- the interval state and the orbit counter move only on markers,
- the error flag only rises on a marker,
- no update overlaps a sweep, and a sweep ends on the last slot,
- the bypass forwards the value just written,
- a start is blocked during a sweep.

The per-slot totals under different hit patterns are shown only by the bench scenarios, which compare them against a behavioural model of the counting rules. The same holds for saturation, rejected clears, and the accumulated result of back-to-back same-slot updates.

// File: rtl/lumi_pkg.sv
package lumi_pkg;

  localparam int unsigned NUM_ARR = 4;

  // Field order inside one memory word; also the host read select codes 0..3.
  typedef enum logic [1:0] {
    ARR_EVT_ANY = 2'd0,
    ARR_EVT_AC  = 2'd1,
    ARR_HIT_ANY = 2'd2,
    ARR_HIT_AC  = 2'd3
  } arr_idx_e;

  localparam logic [2:0] SEL_ORBITS = 3'd4;

endpackage

// File: rtl/lumi_slot_tracker.sv
module lumi_slot_tracker #(
  parameter int unsigned NUM_SLOTS = 3564,
  parameter int unsigned SLOT_W    = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              orbit_mark,
  input  logic              err_clr,
  output logic [SLOT_W-1:0] cur_slot,
  output logic              orbit_err
);

  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);

  logic [SLOT_W-1:0] next_q;
  logic              synced_q;
  logic              bad_marker;

  assign cur_slot   = orbit_mark ? '0 : next_q;
  // next_q != 0 means the previous crossing was not the last slot
  assign bad_marker = orbit_mark && synced_q && (next_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      next_q    <= '0;
      synced_q  <= 1'b0;
      orbit_err <= 1'b0;
    end else begin
      next_q <= (cur_slot == LAST_SLOT) ? '0 : cur_slot + 1'b1;
      if (orbit_mark) synced_q <= 1'b1;
      if (err_clr)         orbit_err <= 1'b0;
      else if (bad_marker) orbit_err <= 1'b1;
    end
  end

  // R1
  slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cur_slot <= LAST_SLOT);

  // R1
  slot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_slot != LAST_SLOT) |=> (orbit_mark || cur_slot == SLOT_W'($past(cur_slot) + 1'b1)));

  // R2
  err_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(orbit_err) |-> $past(orbit_mark));

endmodule

// File: rtl/lumi_interval_ctrl.sv
module lumi_interval_ctrl #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             orbit_mark,
  input  logic             start_req,
  input  logic             stop_req,
  input  logic             busy,
  input  logic             orbit_clr,
  output logic             active_q,
  output logic             active_now,
  output logic             start_pend,
  output logic [CNT_W-1:0] orbit_count
);

  logic stop_pend_q;
  logic start_acc;
  logic orbit_tick;

  assign start_acc  = start_req && !busy;
  assign active_now = orbit_mark ? ((active_q | start_pend) & ~stop_pend_q) : active_q;
  assign orbit_tick = orbit_mark && active_now && (orbit_count != '1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q    <= 1'b0;
      start_pend  <= 1'b0;
      stop_pend_q <= 1'b0;
      orbit_count <= '0;
    end else begin
      active_q <= active_now;
      if (stop_req)        start_pend <= 1'b0;
      else if (start_acc)  start_pend <= 1'b1;
      else if (orbit_mark) start_pend <= 1'b0;
      if (stop_req)        stop_pend_q <= 1'b1;
      else if (start_acc)  stop_pend_q <= 1'b0;
      else if (orbit_mark) stop_pend_q <= 1'b0;
      if (orbit_clr)       orbit_count <= '0;
      else if (orbit_tick) orbit_count <= orbit_count + 1'b1;
    end
  end

  // R3
  active_at_marker_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !orbit_mark |=> $stable(active_q));

  // R6
  orbit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!orbit_mark && !orbit_clr) |=> $stable(orbit_count));

endmodule

// File: rtl/lumi_count_rules.sv
module lumi_count_rules
  import lumi_pkg::*;
#(
  parameter int unsigned TUBES = 16,
  parameter int unsigned INC_W = $clog2(2 * TUBES + 1)
) (
  input  logic [TUBES-1:0]                hits_a,
  input  logic [TUBES-1:0]                hits_c,
  output logic [NUM_ARR-1:0][INC_W-1:0]   inc
);

  function automatic logic [INC_W-1:0] tubes_hit(input logic [TUBES-1:0] a,
                                                 input logic [TUBES-1:0] c);
    return INC_W'($countones(a)) + INC_W'($countones(c));
  endfunction

  logic any_a, any_c, both;

  assign any_a = |hits_a;
  assign any_c = |hits_c;
  assign both  = any_a & any_c;

  assign inc[ARR_EVT_ANY] = INC_W'(any_a | any_c);
  assign inc[ARR_EVT_AC]  = INC_W'(both);
  assign inc[ARR_HIT_ANY] = tubes_hit(hits_a, hits_c);
  assign inc[ARR_HIT_AC]  = both ? tubes_hit(hits_a, hits_c) : '0;

endmodule

// File: rtl/lumi_counter_ram.sv
module lumi_counter_ram
  import lumi_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 3564,
  parameter int unsigned SLOT_W    = $clog2(NUM_SLOTS),
  parameter int unsigned CNT_W     = 32,
  parameter int unsigned INC_W     = 6
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            upd_en,
  input  logic [SLOT_W-1:0]               upd_addr,
  input  logic [NUM_ARR-1:0][INC_W-1:0]   upd_inc,
  input  logic                            clr_start,
  output logic                            clr_busy,
  input  logic                            rd_en,
  input  logic [SLOT_W-1:0]               rd_addr,
  output logic [NUM_ARR-1:0][CNT_W-1:0]   rd_word
);

  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);

  function automatic logic [CNT_W-1:0] sat_add(input logic [CNT_W-1:0] base,
                                               input logic [INC_W-1:0] step);
    logic [CNT_W:0] sum;
    sum = {1'b0, base} + {{(CNT_W + 1 - INC_W){1'b0}}, step};
    return sum[CNT_W] ? '1 : sum[CNT_W-1:0];
  endfunction

  logic [NUM_ARR-1:0][CNT_W-1:0] mem [NUM_SLOTS];

  logic                          s1_valid;
  logic [SLOT_W-1:0]             s1_addr;
  logic [NUM_ARR-1:0][INC_W-1:0] s1_inc;
  logic [NUM_ARR-1:0][CNT_W-1:0] s1_mem;
  logic                          s1_byp;
  logic [NUM_ARR-1:0][CNT_W-1:0] s1_byp_word;
  logic [NUM_ARR-1:0][CNT_W-1:0] s1_old;
  logic [NUM_ARR-1:0][CNT_W-1:0] s1_new;

  logic                          wr_en;
  logic [SLOT_W-1:0]             wr_addr;
  logic [NUM_ARR-1:0][CNT_W-1:0] wr_word;
  logic                          hazard;

  logic [SLOT_W-1:0]             clr_idx_q;

  assign s1_old  = s1_byp ? s1_byp_word : s1_mem;
  assign wr_en   = clr_busy || s1_valid;
  assign wr_addr = clr_busy ? clr_idx_q : s1_addr;
  assign wr_word = clr_busy ? '0 : s1_new;
  // a read issued now would miss the write landing on the same edge
  assign hazard  = upd_en && wr_en && (wr_addr == upd_addr);

  for (genvar g = 0; g < NUM_ARR; g++) begin : g_field
    assign s1_new[g] = sat_add(s1_old[g], s1_inc[g]);

    // R7
    sat_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
      s1_valid |-> (s1_new[g] >= s1_old[g]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid  <= 1'b0;
      clr_busy  <= 1'b1;
      clr_idx_q <= '0;
    end else begin
      s1_valid <= upd_en;
      if (clr_start) begin
        clr_busy  <= 1'b1;
        clr_idx_q <= '0;
      end else if (clr_busy) begin
        if (clr_idx_q == LAST_SLOT) clr_busy <= 1'b0;
        else                        clr_idx_q <= clr_idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (upd_en) s1_mem <= mem[upd_addr];
    s1_addr     <= upd_addr;
    s1_inc      <= upd_inc;
    s1_byp      <= hazard;
    s1_byp_word <= wr_word;
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_word;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_word <= (rd_addr <= LAST_SLOT) ? mem[rd_addr] : '0;
  end

  // R8
  bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && $past(s1_valid) && (s1_addr == $past(s1_addr))) |-> (s1_old == $past(s1_new)));

  // R10
  sweep_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clr_busy) |-> ($past(clr_idx_q) == LAST_SLOT));

  // R10
  no_update_in_sweep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_busy |-> !s1_valid);

endmodule

// File: rtl/lumi_bunch_scaler.sv
module lumi_bunch_scaler
  import lumi_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 3564,
  parameter int unsigned TUBES     = 16,
  parameter int unsigned CNT_W     = 32,
  parameter int unsigned SLOT_W    = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              orbit_mark,
  input  logic              l1a,
  input  logic [TUBES-1:0]  hits_a,
  input  logic [TUBES-1:0]  hits_c,
  input  logic              host_start,
  input  logic              host_stop,
  input  logic              host_clear,
  input  logic              rd_en,
  input  logic [2:0]        rd_sel,
  input  logic [SLOT_W-1:0] rd_addr,
  output logic              rd_valid,
  output logic [CNT_W-1:0]  rd_data,
  output logic              interval_active,
  output logic              clr_busy,
  output logic              orbit_err
);

  localparam int unsigned INC_W = $clog2(2 * TUBES + 1);

  logic [SLOT_W-1:0]             cur_slot;
  logic                          active_now;
  logic                          start_pend;
  logic [CNT_W-1:0]              orbit_count;
  logic                          clr_go;
  logic                          upd_en;
  logic [NUM_ARR-1:0][INC_W-1:0] inc;
  logic [NUM_ARR-1:0][CNT_W-1:0] rd_word;
  logic [2:0]                    sel_q;
  logic [CNT_W-1:0]              orb_q;

  assign clr_go = host_clear && !interval_active && !start_pend && !clr_busy;
  assign upd_en = active_now && l1a && !clr_busy;

  lumi_slot_tracker #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_slot (
    .clk(clk), .rst_n(rst_n), .orbit_mark(orbit_mark), .err_clr(clr_go),
    .cur_slot(cur_slot), .orbit_err(orbit_err));

  lumi_interval_ctrl #(.CNT_W(CNT_W)) u_ivl (
    .clk(clk), .rst_n(rst_n), .orbit_mark(orbit_mark), .start_req(host_start),
    .stop_req(host_stop), .busy(clr_busy), .orbit_clr(clr_go),
    .active_q(interval_active), .active_now(active_now), .start_pend(start_pend),
    .orbit_count(orbit_count));

  lumi_count_rules #(.TUBES(TUBES), .INC_W(INC_W)) u_rules (
    .hits_a(hits_a), .hits_c(hits_c), .inc(inc));

  lumi_counter_ram #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W), .CNT_W(CNT_W), .INC_W(INC_W)) u_ram (
    .clk(clk), .rst_n(rst_n), .upd_en(upd_en), .upd_addr(cur_slot), .upd_inc(inc),
    .clr_start(clr_go), .clr_busy(clr_busy), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_word(rd_word));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      sel_q    <= '0;
      orb_q    <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) begin
        sel_q <= rd_sel;
        orb_q <= orbit_count;
      end
    end
  end

  always_comb begin
    rd_data = '0;
    if (sel_q == SEL_ORBITS) rd_data = orb_q;
    else if (!sel_q[2])      rd_data = rd_word[sel_q[1:0]];
  end

  // R9
  rd_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);

  // R11
  start_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_busy |=> !interval_active);

endmodule

// File: tb/sim_lumi_bunch_scaler.sv
`timescale 1ns/1ps
module sim_lumi_bunch_scaler;

  localparam int NS = 12;
  localparam int CW = 8;
  localparam int TB = 16;
  localparam int SW = $clog2(NS);
  localparam longint CMAX = (64'd1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          orbit_mark = 1'b0, l1a = 1'b0;
  logic [TB-1:0] hits_a = '0, hits_c = '0;
  logic          host_start = 1'b0, host_stop = 1'b0, host_clear = 1'b0;
  logic          rd_en = 1'b0;
  logic [2:0]    rd_sel = '0;
  logic [SW-1:0] rd_addr = '0;
  logic          rd_valid, interval_active, clr_busy, orbit_err;
  logic [CW-1:0] rd_data;

  lumi_bunch_scaler #(.NUM_SLOTS(NS), .TUBES(TB), .CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .orbit_mark(orbit_mark), .l1a(l1a),
    .hits_a(hits_a), .hits_c(hits_c), .host_start(host_start),
    .host_stop(host_stop), .host_clear(host_clear), .rd_en(rd_en),
    .rd_sel(rd_sel), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .interval_active(interval_active), .clr_busy(clr_busy), .orbit_err(orbit_err));

  int    checks = 0, errors = 0;
  bit    done = 0, run_chk = 0;
  bit    mark_on = 0, force_mark = 0;
  int    b_phase = 0;
  int    lfsr = 32'h1234_5678;
  string rd_tag = "R9";

  // behavioural reference state
  longint m_cnt [4][NS];
  longint m_orbits, m_rdd;
  bit     m_active, m_sp, m_stp, m_busy, m_err, m_synced, m_rdv;
  int     m_idx, m_next;
  string  m_rd_tag;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin : model
    int  cur;
    bit  nact, clr_ok;
    int  ta, tc;
    if (!rst_n) begin
      foreach (m_cnt[a, s]) m_cnt[a][s] = 0;
      m_orbits = 0; m_active = 0; m_sp = 0; m_stp = 0; m_busy = 1; m_idx = 0;
      m_err = 0; m_synced = 0; m_next = 0; m_rdv = 0; m_rdd = 0;
    end else begin
      m_rdv = rd_en;
      if (rd_en) begin
        m_rd_tag = rd_tag;
        if (rd_sel < 4)       m_rdd = (int'(rd_addr) < NS) ? m_cnt[rd_sel][rd_addr] : 0;
        else if (rd_sel == 4) m_rdd = m_orbits;
        else                  m_rdd = 0;
      end
      clr_ok = host_clear && !m_active && !m_sp && !m_busy;
      cur = orbit_mark ? 0 : m_next;
      if (clr_ok) m_err = 0;
      else if (orbit_mark && m_synced && m_next != 0) m_err = 1;
      if (orbit_mark) m_synced = 1;
      m_next = (cur == NS - 1) ? 0 : cur + 1;
      nact = orbit_mark ? ((m_active || m_sp) && !m_stp) : m_active;
      if (orbit_mark && nact && m_orbits < CMAX) m_orbits++;
      if (clr_ok) m_orbits = 0;
      if (nact && l1a && !m_busy) begin
        ta = $countones(hits_a);
        tc = $countones(hits_c);
        if (ta + tc > 0) m_cnt[0][cur] = (m_cnt[0][cur] + 1 > CMAX) ? CMAX : m_cnt[0][cur] + 1;
        if (ta > 0 && tc > 0) begin
          m_cnt[1][cur] = (m_cnt[1][cur] + 1 > CMAX) ? CMAX : m_cnt[1][cur] + 1;
          m_cnt[3][cur] = (m_cnt[3][cur] + ta + tc > CMAX) ? CMAX : m_cnt[3][cur] + ta + tc;
        end
        m_cnt[2][cur] = (m_cnt[2][cur] + ta + tc > CMAX) ? CMAX : m_cnt[2][cur] + ta + tc;
      end
      if (orbit_mark) begin m_sp = 0; m_stp = 0; end
      if (host_start && !m_busy) begin m_sp = 1; m_stp = 0; end
      if (host_stop) begin m_stp = 1; m_sp = 0; end
      m_active = nact;
      if (clr_ok) begin
        m_busy = 1; m_idx = 0;
        foreach (m_cnt[a, s]) m_cnt[a][s] = 0;
      end else if (m_busy) begin
        if (m_idx == NS - 1) m_busy = 0;
        else m_idx++;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && run_chk) begin
      check(interval_active == m_active, "R3/R11 interval_active", interval_active, m_active);
      check(clr_busy == m_busy, "R10 clr_busy", clr_busy, m_busy);
      check(orbit_err == m_err, "R2 orbit_err", orbit_err, m_err);
      check(rd_valid == m_rdv, "R9 rd_valid", rd_valid, m_rdv);
      if (m_rdv) check(rd_data == CW'(m_rdd), m_rd_tag, rd_data, m_rdd);
    end
  end

  task automatic tick();
    orbit_mark = (mark_on && b_phase == 0) || force_mark;
    @(negedge clk);
    b_phase = orbit_mark ? 1 : ((b_phase == NS - 1) ? 0 : b_phase + 1);
    host_start = 0; host_stop = 0; host_clear = 0; rd_en = 0; force_mark = 0;
  endtask

  task automatic idle(input int n);
    l1a = 0; hits_a = '0; hits_c = '0;
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic next_rand();
    lfsr = lfsr ^ (lfsr << 13);
    lfsr = lfsr ^ (lfsr >>> 17);
    lfsr = lfsr ^ (lfsr << 5);
  endtask

  // mode 0 random, 1 all tubes with accept, 2 random hits without accept, 3 side A only
  task automatic run_orbits(input int n, input int mode);
    for (int i = 0; i < n * NS; i++) begin
      next_rand();
      case (mode)
        0: begin l1a = lfsr[0]; hits_a = lfsr[16:1] & {16{lfsr[29]}}; hits_c = lfsr[31:16] & {16{lfsr[30]}}; end
        1: begin l1a = 1; hits_a = '1; hits_c = '1; end
        2: begin l1a = 0; hits_a = lfsr[15:0]; hits_c = lfsr[31:16]; end
        default: begin l1a = 1; hits_a = lfsr[15:0]; hits_c = '0; end
      endcase
      tick();
    end
    l1a = 0; hits_a = '0; hits_c = '0;
  endtask

  task automatic read_all(input string tag);
    l1a = 0; hits_a = '0; hits_c = '0;
    rd_tag = tag;
    for (int s = 0; s < 4; s++) begin
      for (int a = 0; a < NS; a++) begin
        rd_en = 1; rd_sel = 3'(s); rd_addr = SW'(a);
        tick();
      end
    end
    rd_en = 1; rd_sel = 3'd4; rd_addr = '0;
    tick();
    tick();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // reset state (R10)
    check(clr_busy == 1'b1, "R10 reset clr_busy", clr_busy, 1);
    check(interval_active == 1'b0, "R3 reset interval_active", interval_active, 0);
    check(orbit_err == 1'b0, "R2 reset orbit_err", orbit_err, 0);
    check(rd_valid == 1'b0, "R9 reset rd_valid", rd_valid, 0);
    rst_n = 1;
    run_chk = 1;
    idle(NS + 3);
    read_all("R10 post-reset sweep");

    // counting interval with several patterns
    mark_on = 1; b_phase = 5;
    idle(2);
    host_start = 1; tick();
    run_orbits(1, 2);                 // R4: no accepts, only the orbit counter moves
    run_orbits(2, 3);                 // R5: one-sided hits, no coincidence counts
    run_orbits(3, 0);                 // R1 R5: mixed pattern per slot
    idle(4);
    host_stop = 1; tick();
    run_orbits(1, 0);                 // R3: counting continues until the next marker
    idle(2);
    read_all("R1/R4/R5/R6 interval totals");

    // clear rejected while the interval is open (R10)
    host_start = 1; tick();
    idle(NS + 1);
    host_clear = 1; tick();
    idle(2);
    host_stop = 1; tick();
    idle(NS + 2);
    read_all("R10 rejected clear keeps counts");

    // clear accepted; start during the sweep is ignored (R11)
    host_clear = 1; tick();
    idle(2);
    host_start = 1; tick();
    idle(2 * NS);
    read_all("R10/R11 cleared bank stays empty");

    // back-to-back markers: same slot updated every cycle (R8), misplaced markers (R2)
    host_start = 1; tick();
    idle(NS + 1);
    for (int i = 0; i < 5; i++) begin
      next_rand();
      l1a = 1; hits_a = lfsr[15:0] | 16'h1; hits_c = lfsr[31:16];
      force_mark = 1;
      tick();
    end
    idle(1);
    host_stop = 1; tick();
    idle(2 * NS);
    read_all("R2/R8 back-to-back slot 0");

    // saturation (R7) and orbit count after a clear (R6)
    host_clear = 1; tick();
    idle(NS + 2);
    host_start = 1; tick();
    run_orbits(10, 1);
    host_stop = 1; tick();
    idle(NS + 1);
    read_all("R6/R7 saturation");

    // out-of-range addresses and select codes (R9)
    rd_tag = "R9 out of range";
    rd_en = 1; rd_sel = 3'd2; rd_addr = SW'(NS); tick();
    rd_en = 1; rd_sel = 3'd0; rd_addr = '1; tick();
    rd_en = 1; rd_sel = 3'd5; rd_addr = '0; tick();
    rd_en = 1; rd_sel = 3'd7; rd_addr = SW'(1); tick();
    idle(2);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run incomplete, actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule